// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt lines into one active-high request for a processor core. Each line is sampled through a short synchronizer. It is then latched into a status bit, either on a rising edge or on every cycle the line is high. Which of the two applies is fixed per line by an elaboration parameter.

Software reaches the block through a word-indexed register port with combinational read data. Through that port it can:
- replace the enable mask, or set or clear chosen enable bits in a single write;
- clear latched status bits by writing ones to an acknowledge location;
- read a vector location that names the lowest-numbered line that is both latched and enabled.

A two-bit master control gates the request output. Both bits must be set before the output can assert.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A line whose kind bit is 0 (level) sets its status bit on every clock it is seen high after synchronization. Acknowledging it while the line stays high leaves the bit set.
- R2: A line whose kind bit is 1 (edge) sets its status bit once per rising edge. The status bit is readable three clocks after the line changes: two synchronizer stages, then the latch. A line held high does not set the bit again after it is acknowledged.
- R3: Kind is chosen per line. Kind bits at positions at or above the number of lines have no effect.
- R4: Writing a mask to word 3 (byte offset 0x0C) clears every status bit written as 1. Writing all ones clears all status bits.
- R5: Writing word 2 (0x08) replaces the enable mask. Writing word 4 (0x10) ORs the written bits into the mask. Writing word 5 (0x14) clears the written bits. Other enable bits keep their value. Enable bits above the number of lines read 0.
- R6: Word 1 (0x04) reads as status AND enable. Word 0 (0x00) reads the status bits. Bit n of either belongs to line n.
- R7: Word 6 (0x18) reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when nothing is pending.
- R8: Word 7 (0x1C) holds master enable in bit 0 and request enable in bit 1. Writing 0x3 reads back 0x3. The output irq_o is high one clock after both bits are set and some line is pending, and low otherwise.
- R9: After reset, status, enable and master control read 0. Words 3, 4, 5 and every index of 8 or above read 0. Writes to words 0, 1 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Interrupt lines, asynchronous to clk |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access, 0 otherwise |
| irq_o | output | 1 | Registered interrupt request to the core |

## Verification
The bench builds the block with 12 lines and a kind mask of 0xFFFFF0A5. Lines 0, 2, 5 and 7 are therefore edge lines and the rest are level lines. The mask also carries edge bits above the line count, so ignoring such bits is exercised.

Twelve lines keep the enable mask narrow enough that a set-enable write of all ones shows the unimplemented bits being dropped. A behavioural model then follows every clock through directed and randomized traffic. Its checks cover priority between pending lines, writes that land on the same cycle as a latch hit, and mixed edge and level lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [2:0] {
    RG_STAT   = 3'd0,
    RG_PEND   = 3'd1,
    RG_EN     = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VEC    = 3'd6,
    RG_MASTER = 3'd7
  } reg_idx_e;

  localparam logic [DATA_W-1:0] VEC_NONE = '1;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int unsigned NUM_SRC     = 32,
  parameter logic [31:0] EDGE_KIND   = 32'h0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] status_o
);
  localparam logic [NUM_SRC-1:0] EDGE_MASK = EDGE_KIND[NUM_SRC-1:0];

  logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] seen;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] lvl_hit;
  logic [NUM_SRC-1:0] stat_q, stat_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= src_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= '0;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  assign seen    = sync_q[SYNC_STAGES-1];
  assign hit     = seen & ~(prev_q & EDGE_MASK);
  assign lvl_hit = seen & ~EDGE_MASK;

  always_comb begin
    stat_d = (stat_q & ~ack_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= seen;
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;

  // R1
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_hit != '0) |=> ((status_o & $past(lvl_hit)) == $past(lvl_hit)));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_i & ~hit) != '0) |=> ((status_o & $past(ack_i & ~hit)) == '0));

  // R2
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((EDGE_MASK & seen & prev_q & ack_i) != '0)
      |=> ((status_o & $past(EDGE_MASK & seen & prev_q & ack_i)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0]          pend_i,
  output logic [irqc_pkg::DATA_W-1:0] vec_o
);
  import irqc_pkg::*;

  logic [DATA_W-1:0] vec_d;

  always_comb begin
    vec_d = VEC_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_d = DATA_W'(i);
    end
  end

  assign vec_o = vec_d;

  // R7
  always_comb begin
    vec_none_chk: assert ((pend_i == '0) == (vec_d == VEC_NONE));
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [irqc_pkg::DATA_W-1:0] bus_wdata,
  input  logic [NUM_SRC-1:0]          status_i,
  input  logic [NUM_SRC-1:0]          pend_i,
  input  logic [irqc_pkg::DATA_W-1:0] vec_i,
  output logic [NUM_SRC-1:0]          en_o,
  output logic [1:0]                  master_o,
  output logic [NUM_SRC-1:0]          ack_o,
  output logic [irqc_pkg::DATA_W-1:0] rdata_o
);
  import irqc_pkg::*;

  logic               in_map;
  reg_idx_e           idx;
  logic               wr_stb, rd_stb;
  logic [NUM_SRC-1:0] wmask;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               en_ld;
  logic [1:0]         mst_q, mst_d;
  logic               mst_ld;
  logic [DATA_W-1:0]  rdata_d;

  assign in_map = ((bus_addr >> 3) == '0);
  assign idx    = reg_idx_e'(bus_addr[2:0]);
  assign wr_stb = bus_sel & bus_wr & in_map;
  assign rd_stb = bus_sel & ~bus_wr & in_map;
  assign wmask  = bus_wdata[NUM_SRC-1:0];

  always_comb begin
    en_ld  = 1'b0;
    en_d   = en_q;
    mst_ld = 1'b0;
    mst_d  = mst_q;
    ack_o  = '0;
    if (wr_stb) begin
      unique case (idx)
        RG_EN:     begin en_ld = 1'b1; en_d = wmask;         end
        RG_SETEN:  begin en_ld = 1'b1; en_d = en_q | wmask;  end
        RG_CLREN:  begin en_ld = 1'b1; en_d = en_q & ~wmask; end
        RG_ACK:    ack_o = wmask;
        RG_MASTER: begin mst_ld = 1'b1; mst_d = bus_wdata[1:0]; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ld) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mst_q <= '0;
    else if (mst_ld) mst_q <= mst_d;
  end

  always_comb begin
    rdata_d = '0;
    if (rd_stb) begin
      unique case (idx)
        RG_STAT:   rdata_d = DATA_W'(status_i);
        RG_PEND:   rdata_d = DATA_W'(pend_i);
        RG_EN:     rdata_d = DATA_W'(en_q);
        RG_VEC:    rdata_d = vec_i;
        RG_MASTER: rdata_d = DATA_W'(mst_q);
        default:   rdata_d = '0;
      endcase
    end
  end

  assign en_o     = en_q;
  assign master_o = mst_q;
  assign rdata_o  = rdata_d;

  // R5
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && idx == RG_SETEN) |=> ((en_o & $past(wmask)) == $past(wmask)));

  // R5
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && idx == RG_CLREN) |=> ((en_o & $past(wmask)) == '0));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !in_map) |=> ($stable(en_o) && $stable(master_o)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned NUM_SRC   = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);
  import irqc_pkg::*;

  logic               rs1_q, rs2_q;
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] status, en, ack, pend;
  logic [1:0]         master;
  logic [DATA_W-1:0]  vec;
  logic               irq_q, irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  irqc_capture #(
    .NUM_SRC(NUM_SRC), .EDGE_KIND(EDGE_KIND), .SYNC_STAGES(2)
  ) u_capture (
    .clk(clk), .rst_n(rst_sync_n), .src_i(src_i), .ack_i(ack), .status_o(status)
  );

  assign pend = status & en;

  irqc_prio #(.NUM_SRC(NUM_SRC)) u_prio (.pend_i(pend), .vec_o(vec));

  irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status_i(status), .pend_i(pend), .vec_i(vec),
    .en_o(en), .master_o(master), .ack_o(ack), .rdata_o(bus_rdata)
  );

  always_comb begin
    irq_d = (master == 2'b11) && (pend != '0);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> $past(master == 2'b11 && pend != '0));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (master != 2'b11) |=> !irq_o);
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  localparam int          NS   = 12;
  localparam logic [31:0] KIND = 32'hFFFF_F0A5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          bus_sel, bus_wr;
  logic [3:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(NS), .EDGE_KIND(KIND), .ADDR_W(4)) i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference model
  bit          m_rs1, m_rs2;
  bit [NS-1:0] m_s1, m_s2, m_prev, m_stat, m_en, m_ack, m_hit;
  bit [1:0]    m_me;
  bit          m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_stat = 0; m_en = 0; m_me = 0; m_irq = 0;
    end else begin
      if (m_rs2) begin
        m_hit = '0;
        for (int i = 0; i < NS; i++)
          m_hit[i] = KIND[i] ? (m_s2[i] && !m_prev[i]) : m_s2[i];
        m_irq = (m_me == 2'd3) && ((m_stat & m_en) != 0);
        m_ack = '0;
        if (bus_sel && bus_wr) begin
          case (int'(bus_addr))
            2: m_en = bus_wdata[NS-1:0];
            3: m_ack = bus_wdata[NS-1:0];
            4: m_en = m_en | bus_wdata[NS-1:0];
            5: m_en = m_en & ~bus_wdata[NS-1:0];
            7: m_me = bus_wdata[1:0];
            default: ;
          endcase
        end
        m_stat = (m_stat & ~m_ack) | m_hit;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = src;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  function automatic bit [31:0] model_rd();
    bit [NS-1:0] p;
    p = m_stat & m_en;
    if (!(bus_sel && !bus_wr)) return 32'h0;
    case (int'(bus_addr))
      0: return 32'(m_stat);
      1: return 32'(p);
      2: return 32'(m_en);
      6: begin
        for (int i = 0; i < NS; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
      end
      7: return 32'(m_me);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R1";
      1: return "R6";
      2: return "R5";
      6: return "R7";
      7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && m_rs2 && !done) begin
      check("R8", 32'(irq_o), 32'(m_irq));
      check(tag_of(int'(bus_addr)), bus_rdata, model_rd());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #0.5;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); #0.5;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic expect_rd(int a, logic [31:0] exp, string tag);
    @(negedge clk); #0.5;
    bus_sel = 1; bus_wr = 0; bus_addr = 4'(a);
    @(negedge clk);
    check(tag, bus_rdata, exp);
    #0.5; bus_sel = 0;
  endtask

  task automatic set_src(logic [NS-1:0] v);
    @(negedge clk); #0.5; src = v;
  endtask

  initial begin
    rst_n = 0; src = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R9 reset state
    expect_rd(0, 32'h0, "R9");
    expect_rd(2, 32'h0, "R9");
    expect_rd(7, 32'h0, "R9");
    expect_rd(6, 32'hFFFF_FFFF, "R7");
    check("R8", 32'(irq_o), 32'h0);

    wr(7, 32'h3);
    expect_rd(7, 32'h3, "R8");

    // R5 enable manipulation
    wr(4, 32'h00F);
    wr(4, 32'h030);
    wr(5, 32'h005);
    expect_rd(2, 32'h03A, "R5");
    wr(4, 32'hFFFF_FFFF);
    expect_rd(2, 32'h0FFF, "R5");
    wr(2, 32'h0);
    expect_rd(2, 32'h0, "R5");
    wr(2, 32'h0FF);

    // R1 level line 3
    set_src(12'h008);
    idle(5);
    expect_rd(0, 32'h008, "R1");
    wr(3, 32'h008);
    expect_rd(0, 32'h008, "R1");
    expect_rd(1, 32'h008, "R6");
    expect_rd(6, 32'd3, "R7");
    check("R8", 32'(irq_o), 32'h1);
    set_src(12'h000);
    idle(4);
    wr(3, 32'h008);
    expect_rd(0, 32'h0, "R4");
    idle(2);
    check("R8", 32'(irq_o), 32'h0);

    // R2 edge line 2 held high
    set_src(12'h004);
    idle(5);
    expect_rd(0, 32'h004, "R2");
    wr(3, 32'h004);
    idle(5);
    expect_rd(0, 32'h0, "R2");
    set_src(12'h000);
    idle(4);

    // R3 edge line 0 vs level line 1
    set_src(12'h003);
    idle(5);
    expect_rd(0, 32'h003, "R3");
    wr(3, 32'h003);
    idle(3);
    expect_rd(0, 32'h002, "R3");
    set_src(12'h000);
    idle(4);
    wr(3, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0, "R4");

    // priority and pending with lines 5 (edge) and 9 (level)
    set_src(12'h220);
    idle(5);
    expect_rd(0, 32'h220, "R1");
    expect_rd(1, 32'h020, "R6");
    expect_rd(6, 32'd5, "R7");
    wr(4, 32'h200);
    expect_rd(6, 32'd5, "R7");
    wr(5, 32'h020);
    expect_rd(6, 32'd9, "R7");

    // R9 ignored writes and empty locations
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    expect_rd(0, 32'h220, "R9");
    expect_rd(2, 32'h2DF, "R9");
    expect_rd(3, 32'h0, "R9");
    expect_rd(4, 32'h0, "R9");
    expect_rd(5, 32'h0, "R9");
    expect_rd(9, 32'h0, "R9");

    // R8 master gating
    wr(7, 32'h1);
    expect_rd(7, 32'h1, "R8");
    idle(2);
    check("R8", 32'(irq_o), 32'h0);
    wr(7, 32'h3);
    idle(2);
    check("R8", 32'(irq_o), 32'h1);

    set_src(12'h000);
    idle(4);
    wr(3, 32'hFFFF_FFFF);
    expect_rd(6, 32'hFFFF_FFFF, "R7");

    // randomized traffic, compared every clock against the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk); #0.5;
      if ($urandom_range(0, 3) == 0) src = NS'($urandom);
      bus_sel   = ($urandom_range(0, 1) == 1);
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_addr  = 4'($urandom_range(0, 9));
      bus_wdata = $urandom;
      if (bus_wr && bus_addr == 4'd3 && $urandom_range(0, 3) == 0) bus_wdata = 32'hFFFF_FFFF;
    end
    @(negedge clk); #0.5; bus_sel = 0; bus_wr = 0;
    idle(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule